// File: doc/BRIEF.md
# Byte-Level I2C Master Receiver with Status Codes

This block runs the data phase of an I2C master receiver once the address phase is done. On a start request it clocks in one byte on the bus, MSB first. It then answers the byte with ACK or NACK, as chosen by a software acknowledge-enable bit. It latches the byte, posts an 8-bit status code and raises an interrupt flag.

While the flag is pending, SCL is held low. Software reads the byte, writes the control register and clears the flag. The control bits written at that point choose what comes next: another byte, a repeated START, a STOP, or a STOP followed by a START. The STOP and START request bits clear themselves once their condition has been sent on the bus.

Both bus lines are open-drain. The block only ever pulls a line low, and it samples the wired line through a synchroniser. If the block releases SDA during its own NACK bit but another device holds the line low while SCL is high, the block gives up the bus. It reports arbitration loss and releases both lines.

Top module: `i2crx_master_rx`

## Requirements
- R1: Out of reset, status_o reads F8h, flag_o is 0, sta_o and stp_o are 0, and neither bus line is pulled low.
- R2: Each data bit is sampled on SCL high, MSB first. The W received bits appear on data_o no later than the cycle flag_o rises, and data_o holds while the flag stays set.
- R3: A byte answered with ACK (SDA low during the ninth clock) sets status_o to 50h and raises flag_o.
- R4: A byte answered with NACK (SDA released during the ninth clock) sets status_o to 58h and raises flag_o.
- R5: The acknowledge-enable bit in the control register sets the answer to the next byte: 1 gives ACK and 0 gives NACK. The value that counts is the one held when go_i is pulsed or when the flag is cleared.
- R6: While flag_o is set and status_o is not 38h, scl_low_o is held at 1 and SCL makes no rising edge.
- R7: Clearing the flag with only the STOP bit set sends exactly one STOP condition (SDA rising while SCL is high) and no START. stp_o then clears by itself, status_o returns to F8h, flag_o stays 0 and both lines are released.
- R8: Clearing the flag with only the START bit set sends exactly one repeated START (SDA falling while SCL is high) and no STOP. It then sets status_o to 10h and raises flag_o, with sta_o cleared and both lines held low.
- R9: Clearing the flag with both bits set sends one STOP and then one START. It then sets status_o to 08h and raises flag_o, with sta_o and stp_o both cleared.
- R10: If SDA is seen low while SCL is high during a NACK bit, the block sets status_o to 38h and raises flag_o. Both lines stay released while that flag is pending.
- R11: Clearing the flag after 38h with START clear returns to status F8h with flag_o 0. Clearing it with START set sends one START once the lines are free and then posts 08h.
- R12: Clearing the flag after 50h with neither START nor STOP set starts the next byte at once, with no START or STOP condition in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Pulse: start receiving a byte; honoured only while idle or parked after a START |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_ack_en_i | input | 1 | Acknowledge-enable value to write |
| ctl_sta_i | input | 1 | START request value to write |
| ctl_stp_i | input | 1 | STOP request value to write |
| ctl_clr_flag_i | input | 1 | With ctl_we_i, clears the interrupt flag |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low |
| sda_low_o | output | 1 | 1 pulls SDA low |
| flag_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |
| data_o | output | W | Last received byte |
| sta_o | output | 1 | START request bit readback |
| stp_o | output | 1 | STOP request bit readback |

## Verification
The assertions take for granted that software writes the control register only while the flag is pending, apart from setting acknowledge-enable before a go pulse. They also take for granted that go_i is pulsed only when the block is idle or parked. The bench keeps to this: it waits for the flag before every write, and it pulses go only after a STOP has completed or after a START flag has been cleared. The modelled slave changes SDA only while SCL is low, so every START or STOP the bench counts comes from the block. The single exception is the bench releasing an arbitration hold, and the bench takes a fresh count snapshot after that release.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PARK, ST_BIT, ST_HOLD, ST_HOLD_CTL,
    ST_STOP, ST_RSTART, ST_START, ST_LOST
  } state_e;

  localparam logic [7:0] CODE_START  = 8'h08;
  localparam logic [7:0] CODE_RSTART = 8'h10;
  localparam logic [7:0] CODE_LOST   = 8'h38;
  localparam logic [7:0] CODE_ACK    = 8'h50;
  localparam logic [7:0] CODE_NACK   = 8'h58;
  localparam logic [7:0] CODE_IDLE   = 8'hF8;
endpackage

// File: rtl/i2crx_sync.sv
module i2crx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o
);
  logic [1:0] raw_w, syn_w;
  assign raw_w = {scl_i, sda_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-2:0], raw_w[l]};
    end
    assign syn_w[l] = pipe_q[STAGES-1];
  end

  assign scl_o = syn_w[1];
  assign sda_o = syn_w[0];
endmodule

// File: rtl/i2crx_shift.sv
module i2crx_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_o
);
  logic [W-1:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[W-2:0], bit_i};
  end
  assign byte_o = sh_q;
endmodule

// File: rtl/i2crx_ctl.sv
module i2crx_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic ack_en_wr_i,
  input  logic sta_wr_i,
  input  logic stp_wr_i,
  input  logic clr_flag_i,
  input  logic set_flag_i,
  input  logic clr_sta_i,
  input  logic clr_stp_i,
  output logic flag_o,
  output logic ack_en_o,
  output logic sta_o,
  output logic stp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o   <= 1'b0;
      ack_en_o <= 1'b0;
      sta_o    <= 1'b0;
      stp_o    <= 1'b0;
    end else begin
      if (set_flag_i)             flag_o <= 1'b1;
      else if (we_i & clr_flag_i) flag_o <= 1'b0;

      if (we_i) ack_en_o <= ack_en_wr_i;

      if (we_i)           sta_o <= sta_wr_i;
      else if (clr_sta_i) sta_o <= 1'b0;

      if (we_i)           stp_o <= stp_wr_i;
      else if (clr_stp_i) stp_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2crx_fsm.sv
module i2crx_fsm
  import i2crx_pkg::*;
#(
  parameter int W   = 8,
  parameter int DIV = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic         scl_s_i,
  input  logic         sda_s_i,
  input  logic         flag_i,
  input  logic         sta_i,
  input  logic         stp_i,
  input  logic         ack_en_i,
  input  logic [W-1:0] rx_byte_i,
  output logic         shift_en_o,
  output logic         set_flag_o,
  output logic         clr_sta_o,
  output logic         clr_stp_o,
  output logic         scl_low_o,
  output logic         sda_low_o,
  output logic [7:0]   status_o,
  output logic [W-1:0] data_o
);
  localparam int QW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(W + 1);
  localparam logic [QW-1:0] QMAX = QW'(DIV - 1);
  localparam logic [BW-1:0] LAST = BW'(W);

  state_e        state_q, state_d;
  logic [1:0]    ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          ack_q, ack_d;
  logic [7:0]    status_q, status_d;
  logic [W-1:0]  data_q, data_d;
  logic          tick, lost, ack_bit;

  assign tick    = (qcnt_q == QMAX);
  assign ack_bit = (bit_q == LAST);
  // another driver holds SDA low while this block releases it for NACK
  assign lost    = ack_bit & ~ack_q & ~sda_s_i;

  always_comb begin
    state_d    = state_q;
    ph_d       = ph_q;
    bit_d      = bit_q;
    ack_d      = ack_q;
    status_d   = status_q;
    data_d     = data_q;
    qcnt_d     = tick ? '0 : qcnt_q + 1'b1;
    shift_en_o = 1'b0;
    set_flag_o = 1'b0;
    clr_sta_o  = 1'b0;
    clr_stp_o  = 1'b0;

    unique case (state_q)
      ST_IDLE, ST_PARK: begin
        qcnt_d = '0;
        if (go_i) begin
          state_d = ST_BIT;
          ph_d    = 2'd0;
          bit_d   = '0;
          ack_d   = ack_en_i;
        end
      end

      ST_BIT: begin
        case (ph_q)
          2'd0, 2'd1: if (tick) ph_d = ph_q + 2'd1;
          2'd2: begin
            qcnt_d = '0;
            if (scl_s_i) begin
              if (lost) begin
                state_d    = ST_LOST;
                status_d   = CODE_LOST;
                set_flag_o = 1'b1;
              end else begin
                shift_en_o = ~ack_bit;
                ph_d       = 2'd3;
              end
            end
          end
          default: begin
            if (lost) begin
              state_d    = ST_LOST;
              status_d   = CODE_LOST;
              set_flag_o = 1'b1;
            end else if (tick) begin
              if (ack_bit) begin
                data_d     = rx_byte_i;
                status_d   = ack_q ? CODE_ACK : CODE_NACK;
                set_flag_o = 1'b1;
                state_d    = ST_HOLD;
              end else begin
                bit_d = bit_q + 1'b1;
                ph_d  = 2'd0;
              end
            end
          end
        endcase
      end

      ST_HOLD: begin
        qcnt_d = '0;
        ph_d   = 2'd0;
        if (!flag_i) begin
          if (stp_i)      state_d = ST_STOP;
          else if (sta_i) state_d = ST_RSTART;
          else begin
            state_d = ST_BIT;
            bit_d   = '0;
            ack_d   = ack_en_i;
          end
        end
      end

      ST_HOLD_CTL: begin
        qcnt_d = '0;
        if (!flag_i) state_d = ST_PARK;
      end

      ST_LOST: begin
        qcnt_d = '0;
        ph_d   = 2'd0;
        if (!flag_i) begin
          if (sta_i) state_d = ST_START;
          else begin
            state_d  = ST_IDLE;
            status_d = CODE_IDLE;
          end
        end
      end

      ST_STOP, ST_RSTART: begin
        case (ph_q)
          2'd0, 2'd2: if (tick) ph_d = ph_q + 2'd1;
          2'd1: begin
            qcnt_d = '0;
            if (scl_s_i) ph_d = 2'd2;
          end
          default: begin
            if (tick) begin
              ph_d = 2'd0;
              if (state_q == ST_STOP) begin
                clr_stp_o = 1'b1;
                if (sta_i) state_d = ST_START;
                else begin
                  state_d  = ST_IDLE;
                  status_d = CODE_IDLE;
                end
              end else begin
                clr_sta_o  = 1'b1;
                set_flag_o = 1'b1;
                status_d   = CODE_RSTART;
                state_d    = ST_HOLD_CTL;
              end
            end
          end
        endcase
      end

      ST_START: begin
        if (tick) begin
          if (ph_q == 2'd0) ph_d = 2'd1;
          else begin
            clr_sta_o  = 1'b1;
            set_flag_o = 1'b1;
            status_d   = CODE_START;
            state_d    = ST_HOLD_CTL;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ph_q     <= 2'd0;
      bit_q    <= '0;
      qcnt_q   <= '0;
      ack_q    <= 1'b0;
      status_q <= CODE_IDLE;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      ph_q     <= ph_d;
      bit_q    <= bit_d;
      qcnt_q   <= qcnt_d;
      ack_q    <= ack_d;
      status_q <= status_d;
      data_q   <= data_d;
    end
  end

  // SDA only changes while SCL is low or already stable, so no false conditions
  always_comb begin
    scl_low_o = 1'b0;
    sda_low_o = 1'b0;
    unique case (state_q)
      ST_PARK, ST_HOLD_CTL: begin
        scl_low_o = 1'b1;
        sda_low_o = 1'b1;
      end
      ST_BIT: begin
        scl_low_o = (ph_q < 2'd2);
        sda_low_o = ack_bit & ack_q & (ph_q != 2'd0);
      end
      ST_HOLD: begin
        scl_low_o = 1'b1;
        sda_low_o = ack_q;
      end
      ST_STOP: begin
        scl_low_o = (ph_q == 2'd0);
        sda_low_o = (ph_q != 2'd3);
      end
      ST_RSTART: begin
        scl_low_o = (ph_q == 2'd0);
        sda_low_o = (ph_q == 2'd3);
      end
      ST_START: sda_low_o = (ph_q == 2'd1);
      default: ;
    endcase
  end

  assign status_o = status_q;
  assign data_o   = data_q;
endmodule

// File: rtl/i2crx_master_rx.sv
module i2crx_master_rx #(
  parameter int W           = 8,
  parameter int DIV         = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic         ctl_we_i,
  input  logic         ctl_ack_en_i,
  input  logic         ctl_sta_i,
  input  logic         ctl_stp_i,
  input  logic         ctl_clr_flag_i,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         scl_low_o,
  output logic         sda_low_o,
  output logic         flag_o,
  output logic [7:0]   status_o,
  output logic [W-1:0] data_o,
  output logic         sta_o,
  output logic         stp_o
);
  logic         scl_s, sda_s;
  logic         ack_en, shift_en, set_flag, clr_sta, clr_stp;
  logic [W-1:0] rx_byte;

  i2crx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .scl_o  (scl_s),
    .sda_o  (sda_s)
  );

  i2crx_shift #(.W(W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (shift_en),
    .bit_i  (sda_s),
    .byte_o (rx_byte)
  );

  i2crx_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctl_we_i),
    .ack_en_wr_i (ctl_ack_en_i),
    .sta_wr_i    (ctl_sta_i),
    .stp_wr_i    (ctl_stp_i),
    .clr_flag_i  (ctl_clr_flag_i),
    .set_flag_i  (set_flag),
    .clr_sta_i   (clr_sta),
    .clr_stp_i   (clr_stp),
    .flag_o      (flag_o),
    .ack_en_o    (ack_en),
    .sta_o       (sta_o),
    .stp_o       (stp_o)
  );

  i2crx_fsm #(.W(W), .DIV(DIV)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_i),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .flag_i     (flag_o),
    .sta_i      (sta_o),
    .stp_i      (stp_o),
    .ack_en_i   (ack_en),
    .rx_byte_i  (rx_byte),
    .shift_en_o (shift_en),
    .set_flag_o (set_flag),
    .clr_sta_o  (clr_sta),
    .clr_stp_o  (clr_stp),
    .scl_low_o  (scl_low_o),
    .sda_low_o  (sda_low_o),
    .status_o   (status_o),
    .data_o     (data_o)
  );
endmodule

// File: rtl/i2crx_master_rx_chk.sv
module i2crx_master_rx_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ctl_we_i,
  input logic         scl_low_o,
  input logic         sda_low_o,
  input logic         flag_o,
  input logic [7:0]   status_o,
  input logic [W-1:0] data_o,
  input logic         sta_o,
  input logic         stp_o
);
  p_hold_stretch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && status_o != 8'h38) |-> scl_low_o);

  p_ack_driven_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_o) && status_o == 8'h50) |-> sda_low_o);

  p_nack_released_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_o) && status_o == 8'h58) |-> !sda_low_o);

  p_lost_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && status_o == 8'h38) |-> (!scl_low_o && !sda_low_o));

  p_stop_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stp_o) && !$past(ctl_we_i)) |-> (!scl_low_o && !sda_low_o));

  p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && $past(flag_o)) |-> $stable(data_o));

  p_rstart_park_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_o) && status_o == 8'h10) |-> (scl_low_o && sda_low_o && !sta_o));

  p_both_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_o) && status_o == 8'h08) |-> (!sta_o && !stp_o));
endmodule

bind i2crx_master_rx i2crx_master_rx_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctl_we_i  (ctl_we_i),
  .scl_low_o (scl_low_o),
  .sda_low_o (sda_low_o),
  .flag_o    (flag_o),
  .status_o  (status_o),
  .data_o    (data_o),
  .sta_o     (sta_o),
  .stp_o     (stp_o)
);

// File: tb/i2crx_master_rx_tb_top.sv
`timescale 1ns/100ps
module i2crx_master_rx_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, we = 1'b0, w_ack = 1'b0, w_sta = 1'b0, w_stp = 1'b0, w_clr = 1'b0;
  logic scl_low, sda_low, flag, sta_rb, stp_rb;
  logic [7:0] status;
  logic [W-1:0] data;

  logic slv_low = 1'b0, arb_hold = 1'b0, arb_mode = 1'b0, ack_seen = 1'b1;
  logic [7:0] slv_byte = 8'h00;
  int   slv_cnt = 9;
  logic prep_tgl = 1'b0, prep_seen = 1'b0, scl_prev = 1'b1, sda_prev = 1'b1;
  int   starts = 0, stops = 0, scl_rises = 0;
  int   checks = 0, fails = 0;

  wire scl_line = ~scl_low;
  wire sda_line = ~(sda_low | slv_low | (arb_hold & arb_mode));

  always #2.5 clk = ~clk;

  i2crx_master_rx #(.W(W), .DIV(4), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .ctl_we_i(we),
    .ctl_ack_en_i(w_ack), .ctl_sta_i(w_sta), .ctl_stp_i(w_stp), .ctl_clr_flag_i(w_clr),
    .scl_i(scl_line), .sda_i(sda_line), .scl_low_o(scl_low), .sda_low_o(sda_low),
    .flag_o(flag), .status_o(status), .data_o(data), .sta_o(sta_rb), .stp_o(stp_rb)
  );

  // slave model: changes SDA only while SCL is low
  always @(scl_line, prep_tgl) begin
    if (prep_tgl != prep_seen) begin
      prep_seen = prep_tgl;
      slv_cnt   = 0;
      arb_hold  = 1'b0;
      if (!scl_line) slv_low = ~slv_byte[7];
    end else if (scl_line && !scl_prev) begin
      if (slv_cnt == 8) ack_seen = sda_line;
      slv_cnt = slv_cnt + 1;
      scl_rises = scl_rises + 1;
    end else if (!scl_line && scl_prev) begin
      if (slv_cnt < 8) slv_low = ~slv_byte[7 - slv_cnt];
      else             slv_low = 1'b0;
      if (slv_cnt == 8) arb_hold = 1'b1;
    end
    scl_prev = scl_line;
  end

  always @(sda_line) begin
    if (scl_line === 1'b1 && sda_prev !== sda_line) begin
      if (sda_line) stops = stops + 1;
      else          starts = starts + 1;
    end
    sda_prev = sda_line;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic s, input logic p, input logic c);
    @(negedge clk);
    we = 1'b1; w_ack = a; w_sta = s; w_stp = p; w_clr = c;
    @(negedge clk);
    we = 1'b0; w_clr = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic prep(input logic [7:0] b);
    slv_byte = b;
    prep_tgl = ~prep_tgl;
    #0.1;
  endtask

  task automatic wait_flag();
    while (flag !== 1'b1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    int s0, p0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk(!flag && !sta_rb && !stp_rb, "R1 flag/sta/stp", {flag, sta_rb, stp_rb}, 0);
    chk(!scl_low && !sda_low, "R1 lines", {scl_low, sda_low}, 0);

    for (int g = 0; g < 64; g++) begin
      wr(1'b1, 1'b0, 1'b0, 1'b0);
      prep(8'(g * 4));
      pulse_go();
      for (int j = 0; j < 4; j++) begin
        logic [7:0] v;
        v = 8'(g * 4 + j);
        wait_flag();
        @(negedge clk);
        if (j == 0) chk(data == v, "R2 data", data, v);
        else        chk(data == v, "R2 R12 data", data, v);
        if (j < 3) chk(status == 8'h50, "R3 status", status, 8'h50);
        else       chk(status == 8'h58, "R4 status", status, 8'h58);
        chk(ack_seen == (j == 3), "R5 ack level", ack_seen, (j == 3));
        if (g < 4) begin
          r0 = scl_rises;
          repeat (20) @(negedge clk);
          chk(scl_rises == r0 && scl_low && flag, "R6 stretch", scl_rises - r0, 0);
        end
        if (j < 3) begin
          s0 = starts; p0 = stops;
          prep(8'(g * 4 + j + 1));
          wr((j + 1) < 3, 1'b0, 1'b0, 1'b1);
          if (j == 0) begin
            wait_flag();
            chk(starts == s0 && stops == p0, "R12 no condition", starts - s0 + stops - p0, 0);
          end
        end
      end
      s0 = starts; p0 = stops;
      case (g % 3)
        0: begin
          wr(1'b0, 1'b0, 1'b1, 1'b1);
          while (stp_rb) @(negedge clk);
          @(negedge clk);
          chk(stops - p0 == 1 && starts == s0, "R7 stop count", stops - p0, 1);
          chk(status == 8'hF8 && !flag, "R7 idle", status, 8'hF8);
          chk(!scl_low && !sda_low, "R7 released", {scl_low, sda_low}, 0);
        end
        1: begin
          wr(1'b0, 1'b1, 1'b0, 1'b1);
          wait_flag();
          @(negedge clk);
          chk(status == 8'h10, "R8 status", status, 8'h10);
          chk(starts - s0 == 1 && stops == p0, "R8 counts", starts - s0, 1);
          chk(!sta_rb && scl_low && sda_low, "R8 sta/lines", {sta_rb, scl_low, sda_low}, 3);
        end
        default: begin
          wr(1'b0, 1'b1, 1'b1, 1'b1);
          wait_flag();
          @(negedge clk);
          chk(status == 8'h08, "R9 status", status, 8'h08);
          chk(starts - s0 == 1 && stops - p0 == 1, "R9 counts", {starts - s0, stops - p0}, 2);
          chk(!sta_rb && !stp_rb, "R9 bits clear", {sta_rb, stp_rb}, 0);
        end
      endcase
      if (g % 3 != 0) begin
        wr(1'b0, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk(!flag && scl_low, "R8 R9 parked", {flag, scl_low}, 1);
      end
    end

    // arbitration loss, then release to idle
    wr(1'b0, 1'b0, 1'b0, 1'b0);
    prep(8'hA5);
    arb_mode = 1'b1;
    pulse_go();
    wait_flag();
    @(negedge clk);
    chk(status == 8'h38, "R10 status", status, 8'h38);
    chk(!scl_low && !sda_low && scl_line, "R10 released", {scl_low, sda_low, scl_line}, 1);
    arb_mode = 1'b0;
    repeat (5) @(negedge clk);
    wr(1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(!flag && status == 8'hF8, "R11 to idle", status, 8'hF8);

    // arbitration loss, then START on clear
    prep(8'h3C);
    arb_mode = 1'b1;
    pulse_go();
    wait_flag();
    @(negedge clk);
    chk(status == 8'h38, "R10 status again", status, 8'h38);
    arb_mode = 1'b0;
    repeat (5) @(negedge clk);
    s0 = starts;
    wr(1'b0, 1'b1, 1'b0, 1'b1);
    wait_flag();
    @(negedge clk);
    chk(status == 8'h08, "R11 start status", status, 8'h08);
    chk(starts - s0 == 1, "R11 start count", starts - s0, 1);

    finish_run();
  end
endmodule